// File: doc/BRIEF.md
# Pipelined Streaming Quadratic Evaluator

This block evaluates the second-order polynomial y = a·x² + b·x + c on a stream of signed samples, one sample per clock. Three coefficient registers hold a, b and c. They are written together through a single load strobe. Each sample enters with a valid strobe. Its result leaves a fixed number of cycles later with a matching valid strobe.

The expression is cut into three register-separated stages of similar depth:

- The first stage squares x and multiplies b by x.
- The second stage scales the square by a and adds c to b·x.
- The third stage adds the two partial results.

No arithmetic operator is split internally. The clock period is therefore set by one multiplier or one wide adder, not by the whole chain. Once the pipeline is full, a result comes out every cycle.

Every sample carries a snapshot of the coefficients along the pipeline. A coefficient reload therefore never mixes old and new values inside one result. There is no backpressure: the consumer must accept every valid result.

Top module: `quad_stream_eval`

## Requirements
- R1: While reset is asserted and in the first cycles after its release, out_valid is 0 and y_out is 0.
- R2: For every accepted sample, y_out equals a·x² + b·x + c, computed exactly in signed two's complement at the full y_out width. x, a, b and c are signed 16-bit values and y_out is a signed 49-bit value.
- R3: A sample accepted at a rising edge (in_valid high) shows up on y_out with out_valid high right after the third rising edge, counting the accepting edge as the first.
- R4: Samples presented on consecutive cycles produce results on consecutive cycles, in the same order, with no stall.
- R5: out_valid is exactly in_valid delayed by three cycles. Gaps in the input stream reappear as gaps of the same length at the output, and no result is produced that was not requested.
- R6: While out_valid is 0, y_out keeps its previous value. A sample presented while in_valid is 0 has no effect on any later result.
- R7: When coef_we is high at a rising edge, a, b and c are loaded together. A sample presented in that same cycle uses the old coefficients. Later samples use the new ones. A sample already in the pipeline keeps the coefficients it entered with.
- R8: Extreme operands (x, a, b, c each equal to -32768 or 32767) give the exact result, without wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| coef_we | input | 1 | Loads coef_a, coef_b and coef_c into the coefficient registers |
| coef_a | input | 16 | Signed coefficient of x² |
| coef_b | input | 16 | Signed coefficient of x |
| coef_c | input | 16 | Signed constant term |
| in_valid | input | 1 | Marks x_in as a sample to evaluate |
| x_in | input | 16 | Signed input sample |
| out_valid | output | 1 | Marks y_out as a fresh result |
| y_out | output | 49 | Signed result a·x² + b·x + c |

## Verification
A dense run of small consecutive x values checks the arithmetic and confirms that one result leaves per cycle. Alternating and irregular valid patterns, with junk on x_in during idle cycles, separate a correct valid delay from an off-by-one latency and show whether idle data leaks into results. Coefficient reloads placed between and on top of samples in flight separate per-sample coefficient snapshots from coefficients read live in later stages. Saturating operand corners and a long random stream expose truncated product or sum widths.

// File: rtl/qpipe_pkg.sv
package qpipe_pkg;

  // Number of register-separated stages in the evaluator.
  localparam int unsigned PIPE_DEPTH = 3;

  // Width of an exact signed product.
  function automatic int unsigned prod_w(input int unsigned wa, input int unsigned wb);
    return wa + wb;
  endfunction

  // Width of an exact signed sum of two operands.
  function automatic int unsigned sum_w(input int unsigned wa, input int unsigned wb);
    return ((wa > wb) ? wa : wb) + 1;
  endfunction

endpackage

// File: rtl/qpipe_rst_sync.sv
module qpipe_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/qpipe_coef_regs.sv
module qpipe_coef_regs #(
  parameter int unsigned CW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic signed [CW-1:0] a_i,
  input  logic signed [CW-1:0] b_i,
  input  logic signed [CW-1:0] c_i,
  output logic signed [CW-1:0] a_o,
  output logic signed [CW-1:0] b_o,
  output logic signed [CW-1:0] c_o
);

  logic signed [CW-1:0] a_d, b_d, c_d;

  always_comb begin
    a_d = a_o;
    b_d = b_o;
    c_d = c_o;
    if (load_i) begin
      a_d = a_i;
      b_d = b_i;
      c_d = c_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_o <= '0;
      b_o <= '0;
      c_o <= '0;
    end else begin
      a_o <= a_d;
      b_o <= b_d;
      c_o <= c_d;
    end
  end

endmodule

// File: rtl/qpipe_valid_pipe.sv
module qpipe_valid_pipe #(
  parameter int unsigned DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vin_i,
  output logic [DEPTH-1:0] v_o
);

  logic [DEPTH-1:0] v_d;

  generate
    if (DEPTH == 1) begin : g_single
      always_comb v_d = vin_i;
    end else begin : g_shift
      always_comb v_d = {v_o[DEPTH-2:0], vin_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o <= '0;
    end else begin
      v_o <= v_d;
    end
  end

endmodule

// File: rtl/qpipe_stage1.sv
// First cut: square of x, b times x, and a snapshot of a and c for later stages.
module qpipe_stage1 #(
  parameter int unsigned XW  = 16,
  parameter int unsigned CW  = 16,
  parameter int unsigned SQW = 32,
  parameter int unsigned BXW = 32
) (
  input  logic                  clk,
  input  logic                  en_i,
  input  logic signed [XW-1:0]  x_i,
  input  logic signed [CW-1:0]  a_i,
  input  logic signed [CW-1:0]  b_i,
  input  logic signed [CW-1:0]  c_i,
  output logic signed [SQW-1:0] sq_o,
  output logic signed [BXW-1:0] bx_o,
  output logic signed [CW-1:0]  a_o,
  output logic signed [CW-1:0]  c_o
);

  logic signed [SQW-1:0] sq_d;
  logic signed [BXW-1:0] bx_d;

  always_comb begin
    sq_d = SQW'(x_i) * SQW'(x_i);
    bx_d = BXW'(b_i) * BXW'(x_i);
  end

  always_ff @(posedge clk) begin
    if (en_i) begin
      sq_o <= sq_d;
      bx_o <= bx_d;
      a_o  <= a_i;
      c_o  <= c_i;
    end
  end

endmodule

// File: rtl/qpipe_stage2.sv
// Second cut: scale the square by a, fold c into b*x.
module qpipe_stage2 #(
  parameter int unsigned CW   = 16,
  parameter int unsigned SQW  = 32,
  parameter int unsigned BXW  = 32,
  parameter int unsigned AXW  = 48,
  parameter int unsigned BXCW = 33
) (
  input  logic                   clk,
  input  logic                   en_i,
  input  logic signed [SQW-1:0]  sq_i,
  input  logic signed [BXW-1:0]  bx_i,
  input  logic signed [CW-1:0]   a_i,
  input  logic signed [CW-1:0]   c_i,
  output logic signed [AXW-1:0]  ax2_o,
  output logic signed [BXCW-1:0] bxc_o
);

  logic signed [AXW-1:0]  ax2_d;
  logic signed [BXCW-1:0] bxc_d;

  always_comb begin
    ax2_d = AXW'(a_i) * AXW'(sq_i);
    bxc_d = BXCW'(bx_i) + BXCW'(c_i);
  end

  always_ff @(posedge clk) begin
    if (en_i) begin
      ax2_o <= ax2_d;
      bxc_o <= bxc_d;
    end
  end

endmodule

// File: rtl/qpipe_stage3.sv
// Final cut: one wide addition into the output register.
module qpipe_stage3 #(
  parameter int unsigned AXW  = 48,
  parameter int unsigned BXCW = 33,
  parameter int unsigned YW   = 49
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en_i,
  input  logic signed [AXW-1:0]  ax2_i,
  input  logic signed [BXCW-1:0] bxc_i,
  output logic signed [YW-1:0]   y_o
);

  logic signed [YW-1:0] y_d;

  always_comb begin
    y_d = y_o;
    if (en_i) begin
      y_d = YW'(ax2_i) + YW'(bxc_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_o <= '0;
    end else begin
      y_o <= y_d;
    end
  end

endmodule

// File: rtl/quad_stream_eval.sv
module quad_stream_eval #(
  parameter  int unsigned XW = 16,
  parameter  int unsigned CW = 16,
  localparam int unsigned YW = 2 * XW + CW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 coef_we,
  input  logic signed [CW-1:0] coef_a,
  input  logic signed [CW-1:0] coef_b,
  input  logic signed [CW-1:0] coef_c,
  input  logic                 in_valid,
  input  logic signed [XW-1:0] x_in,
  output logic                 out_valid,
  output logic signed [YW-1:0] y_out
);

  import qpipe_pkg::*;

  localparam int unsigned DEPTH = PIPE_DEPTH;
  localparam int unsigned SQW   = prod_w(XW, XW);
  localparam int unsigned BXW   = prod_w(CW, XW);
  localparam int unsigned AXW   = prod_w(CW, SQW);
  localparam int unsigned BXCW  = sum_w(BXW, CW);

  logic                   rst_q_n;
  logic signed [CW-1:0]   coef_a_q, coef_b_q, coef_c_q;
  logic [DEPTH-1:0]       vld_q;
  logic signed [SQW-1:0]  s1_sq;
  logic signed [BXW-1:0]  s1_bx;
  logic signed [CW-1:0]   s1_a, s1_c;
  logic signed [AXW-1:0]  s2_ax2;
  logic signed [BXCW-1:0] s2_bxc;

  qpipe_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_q_n)
  );

  qpipe_coef_regs #(.CW(CW)) coef_i (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .load_i (coef_we),
    .a_i    (coef_a),
    .b_i    (coef_b),
    .c_i    (coef_c),
    .a_o    (coef_a_q),
    .b_o    (coef_b_q),
    .c_o    (coef_c_q)
  );

  qpipe_valid_pipe #(.DEPTH(DEPTH)) vld_i (
    .clk   (clk),
    .rst_n (rst_q_n),
    .vin_i (in_valid),
    .v_o   (vld_q)
  );

  qpipe_stage1 #(.XW(XW), .CW(CW), .SQW(SQW), .BXW(BXW)) st1_i (
    .clk  (clk),
    .en_i (in_valid),
    .x_i  (x_in),
    .a_i  (coef_a_q),
    .b_i  (coef_b_q),
    .c_i  (coef_c_q),
    .sq_o (s1_sq),
    .bx_o (s1_bx),
    .a_o  (s1_a),
    .c_o  (s1_c)
  );

  qpipe_stage2 #(.CW(CW), .SQW(SQW), .BXW(BXW), .AXW(AXW), .BXCW(BXCW)) st2_i (
    .clk   (clk),
    .en_i  (vld_q[0]),
    .sq_i  (s1_sq),
    .bx_i  (s1_bx),
    .a_i   (s1_a),
    .c_i   (s1_c),
    .ax2_o (s2_ax2),
    .bxc_o (s2_bxc)
  );

  qpipe_stage3 #(.AXW(AXW), .BXCW(BXCW), .YW(YW)) st3_i (
    .clk   (clk),
    .rst_n (rst_q_n),
    .en_i  (vld_q[1]),
    .ax2_i (s2_ax2),
    .bxc_i (s2_bxc),
    .y_o   (y_out)
  );

  assign out_valid = vld_q[DEPTH-1];

endmodule

// File: rtl/qpipe_checker.sv
module qpipe_checker #(
  parameter int unsigned XW = 16,
  parameter int unsigned CW = 16,
  parameter int unsigned YW = 49
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 coef_we,
  input logic signed [CW-1:0] coef_a,
  input logic signed [CW-1:0] coef_b,
  input logic signed [CW-1:0] coef_c,
  input logic signed [CW-1:0] a_q,
  input logic signed [CW-1:0] b_q,
  input logic signed [CW-1:0] c_q,
  input logic                 in_valid,
  input logic signed [XW-1:0] x_in,
  input logic                 out_valid,
  input logic signed [YW-1:0] y_out
);

  // Cycles since reset release, saturating at the pipeline depth.
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
    end else if (since_rst != 2'd3) begin
      since_rst <= since_rst + 2'd1;
    end
  end

  // R1: held in reset, nothing valid and a cleared result
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && y_out == '0));

  // R5: output strobe is the input strobe three cycles late
  p_valid_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R6: result register idles while no result is due
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && !out_valid) |-> $stable(y_out));

  // R7: a load strobe captures all three coefficients together
  p_coef_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    coef_we |=> (a_q == $past(coef_a) && b_q == $past(coef_b) && c_q == $past(coef_c)));

  // R7: without a load strobe the coefficients do not move
  p_coef_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && !$past(coef_we)) |-> ($stable(a_q) && $stable(b_q) && $stable(c_q)));

  // x_in is observed only to keep the checker's view of the ports complete.
  logic unused_x;
  assign unused_x = ^x_in;

endmodule

bind quad_stream_eval qpipe_checker #(.XW(XW), .CW(CW), .YW(YW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .coef_we   (coef_we),
  .coef_a    (coef_a),
  .coef_b    (coef_b),
  .coef_c    (coef_c),
  .a_q       (coef_a_q),
  .b_q       (coef_b_q),
  .c_q       (coef_c_q),
  .in_valid  (in_valid),
  .x_in      (x_in),
  .out_valid (out_valid),
  .y_out     (y_out)
);

// File: tb/quad_stream_eval_tb.sv
module quad_stream_eval_tb_top;

  localparam int unsigned XW = 16;
  localparam int unsigned CW = 16;
  localparam int unsigned YW = 2 * XW + CW + 1;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 coef_we;
  logic signed [CW-1:0] coef_a, coef_b, coef_c;
  logic                 in_valid;
  logic signed [XW-1:0] x_in;
  logic                 out_valid;
  logic signed [YW-1:0] y_out;

  always #10 clk = ~clk;

  quad_stream_eval #(.XW(XW), .CW(CW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .coef_we   (coef_we),
    .coef_a    (coef_a),
    .coef_b    (coef_b),
    .coef_c    (coef_c),
    .in_valid  (in_valid),
    .x_in      (x_in),
    .out_valid (out_valid),
    .y_out     (y_out)
  );

  typedef struct {
    longint      val;
    int unsigned due;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int unsigned cyc = 0;
  int          checks = 0;
  int          bad = 0;
  bit          mon_on = 1'b0;
  bit          finished = 1'b0;
  longint      ma = 0, mb = 0, mc = 0;
  longint      last_y = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  // Driver: one cycle of stimulus; expected value uses coefficients in force before any load now.
  task automatic step(input bit v, input longint xv, input bit we = 1'b0,
                      input longint na = 0, input longint nb = 0, input longint nc = 0,
                      input string tag = "R2");
    exp_t e;
    @(negedge clk);
    in_valid = v;
    x_in     = XW'(xv);
    coef_we  = we;
    coef_a   = CW'(na);
    coef_b   = CW'(nb);
    coef_c   = CW'(nc);
    if (v) begin
      e.val = ma * xv * xv + mb * xv + mc;
      e.due = cyc + 3;
      e.tag = tag;
      sb.push_back(e);
    end
    if (we) begin
      ma = na;
      mb = nb;
      mc = nc;
    end
  endtask

  // Monitor: pops due results and checks idle cycles.
  always @(negedge clk) begin
    if (mon_on) begin
      longint act;
      act = longint'(y_out);
      if (sb.size() > 0 && sb[0].due == cyc) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (!out_valid || act != e.val) begin
          bad++;
          $display("FAIL %s (R3 timing): valid=%0b y=%0d expected valid=1 y=%0d",
                   e.tag, out_valid, act, e.val);
        end
      end else if (out_valid) begin
        checks++;
        bad++;
        $display("FAIL R5: unexpected out_valid=1 y=%0d expected out_valid=0", act);
      end else begin
        checks++;
        if (act != last_y) begin
          bad++;
          $display("FAIL R6: idle y=%0d expected held %0d", act, last_y);
        end
      end
      last_y = act;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL R4 watchdog: actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; coef_we = 1'b0; coef_a = '0; coef_b = '0; coef_c = '0;
    in_valid = 1'b0; x_in = '0;
    repeat (3) @(negedge clk);
    // R1: during reset
    checks++;
    if (out_valid !== 1'b0 || y_out !== '0) begin
      bad++;
      $display("FAIL R1: in reset valid=%0b y=%0d expected 0 0", out_valid, y_out);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: after release
    checks++;
    if (out_valid !== 1'b0 || y_out !== '0) begin
      bad++;
      $display("FAIL R1: after release valid=%0b y=%0d expected 0 0", out_valid, y_out);
    end
    mon_on = 1'b1;

    // R2/R4: back-to-back small values
    step(1'b0, 0, 1'b1, 3, -5, 7);
    for (int i = -6; i <= 6; i++) step(1'b1, i, 1'b0, 0, 0, 0, "R4");
    repeat (4) step(1'b0, 999);

    // R3: isolated sample
    step(1'b1, 11, 1'b0, 0, 0, 0, "R3");
    repeat (5) step(1'b0, -77);

    // R5/R6: gaps with junk x while idle
    for (int i = 0; i < 12; i++) begin
      step(1'b1, 100 + i, 1'b0, 0, 0, 0, "R5");
      step(1'b0, -12345);
      if (i % 3 == 0) step(1'b0, 31000);
    end
    repeat (4) step(1'b0, 5);

    // R7: reload in the same cycle as a sample, and while samples are in flight
    step(1'b1, 10, 1'b1, -2, 9, -100, "R7");
    step(1'b1, 10, 1'b0, 0, 0, 0, "R7");
    step(1'b1, -7, 1'b1, 1000, -1000, 32767, "R7");
    step(1'b1, -7, 1'b1, 5, 6, 7, "R7");
    step(1'b1, 3, 1'b0, 0, 0, 0, "R7");
    repeat (4) step(1'b0, 0);

    // R8: saturating corners
    step(1'b1, -32768, 1'b1, -32768, -32768, -32768, "R8");
    step(1'b1, 32767, 1'b0, 0, 0, 0, "R8");
    step(1'b1, -32768, 1'b1, 32767, 32767, 32767, "R8");
    step(1'b1, 32767, 1'b0, 0, 0, 0, "R8");
    step(1'b1, -32768, 1'b1, 32767, -32768, 32767, "R8");
    step(1'b1, 32767, 1'b1, -32768, 32767, -32768, "R8");
    step(1'b1, -32768, 1'b0, 0, 0, 0, "R8");
    repeat (4) step(1'b0, 0);

    // R2: random stream with random gaps and occasional reloads
    for (int i = 0; i < 400; i++) begin
      longint rx, ra, rb, rc;
      rx = longint'($signed(16'($urandom)));
      ra = longint'($signed(16'($urandom)));
      rb = longint'($signed(16'($urandom)));
      rc = longint'($signed(16'($urandom)));
      step(($urandom % 4) != 0, rx, ($urandom % 16) == 0, ra, rb, rc, "R2");
    end
    repeat (6) step(1'b0, 0);

    // R5: every requested result was delivered
    checks++;
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL R5: pending results=%0d expected 0", sb.size());
    end
    finished = 1'b1;
    summary();
  end

endmodule